// File: doc/BRIEF.md
# PWM Channel Enable and Pin Override Controller

This block switches four pulse-width channels on and off and decides who owns each of four port pins. Software writes a one-byte enable register over a small register bus. Each enable bit is not used directly. It is re-sampled inside the channel only on the cycle where that channel's clock source starts a new period (a one-cycle tick strobe). The counter's clock enable and the pin takeover both follow that re-sampled copy, so a channel always starts and stops on a whole period and never emits a runt first or last pulse.

While a channel's synchronized enable is high, its pin is forced to drive and carries the channel waveform. The general-purpose direction bit and port data bit are ignored during that time but are never altered, because they stay outside this block. When the enable drops, the pin falls back to those direction and data bits in the same cycle that the counter clock stops. The counters and the duty and period comparators sit outside the block. The block receives their tick strobes and waveforms as plain inputs. There is no data stream here, so every pin is a plain control or status signal and no valid/ready handshake is used.

Top module: `pwm_chan_enable`

## Requirements
- R1: After reset the enable register is 0, the read bus returns 0x00, no counter clock enable is active, each pin's output enable equals its direction bit, and each pin's output value equals its port data bit.
- R2: A cycle with both `bus_sel` and `bus_wr` high loads `bus_wdata[3:0]` into the enable register, effective the next cycle. A write with either strobe low leaves the register unchanged.
- R3: `bus_rdata` always shows the register combinationally: bits 3..0 are the enable bits (bit 0 is channel 1) and bits 7..4 read as 0.
- R4: A channel's synchronized enable copies its register bit only at a clock edge where that channel's `src_tick` bit is high. At every other edge it holds its value.
- R5: If a register write and a tick happen in the same cycle, the tick samples the register value from before that write. The new value takes effect at the following tick.
- R6: `cnt_clk_en[i]` is high exactly when `src_tick[i]` is high and channel i's synchronized enable is high.
- R7: While channel i's synchronized enable is high, `pin_oe[i]` is 1 whatever `port_dir[i]` holds.
- R8: While channel i's synchronized enable is low, `pin_oe[i]` equals `port_dir[i]` and `pin_out[i]` equals `port_dat[i]`. This control returns in the same cycle that the counter clock enable stops.
- R9: While channel i's synchronized enable is high, `pin_out[i]` equals `pwm_wave[i]`.
- R10: Enable bit i and channel i affect only pin i. Channel 1 drives pin 0, channel 2 pin 1, channel 3 pin 2 and channel 4 pin 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, enable bits in 3..0 |
| src_tick | input | 4 | Per-channel strobe marking the start of a clock-source period |
| pwm_wave | input | 4 | Waveform from each channel's comparator |
| port_dir | input | 4 | General-purpose direction bits, 1 = output |
| port_dat | input | 4 | General-purpose port data bits |
| cnt_clk_en | output | 4 | Gated count enable to each channel counter |
| pin_oe | output | 4 | Pin output enable |
| pin_out | output | 4 | Pin output value |

## Verification
The assertions assume that `src_tick` is a clean one-cycle-per-period strobe that is defined from reset onward. They also assume that bus writes are single-cycle strobes. They do not assume any fixed relation between a write and a tick, because the same-edge case is part of the behaviour. The stimulus drives every input on the falling clock edge, so each tick and write is sampled once. It deliberately places a write and a tick on the same edge, and it toggles direction, port data and waveform freely so that the pin takeover is exercised against both direction settings.

// File: rtl/pwmen_pkg.sv
package pwmen_pkg;
  localparam int unsigned PWMEN_NCH   = 4;
  localparam int unsigned PWMEN_BUS_W = 8;

  typedef enum logic {
    OWNER_PORT = 1'b0,
    OWNER_PWM  = 1'b1
  } pin_owner_e;
endpackage

// File: rtl/pwmen_reg.sv
module pwmen_reg #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic [NCH-1:0]   en_bits
);
  localparam int unsigned PAD_W = BUS_W - NCH;

  logic [NCH-1:0] en_q;
  logic           wr_hit;
  logic           unused_hi;

  assign wr_hit    = sel & wr;
  assign unused_hi = ^wdata[BUS_W-1:NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_hit) en_q <= wdata[NCH-1:0];
  end

  assign en_bits = en_q;
  assign rdata   = {{PAD_W{1'b0}}, en_q};

  // R2
  reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr) |=> (en_bits == $past(wdata[NCH-1:0])));

  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr) |=> $stable(en_bits));
endmodule

// File: rtl/pwmen_sync.sv
module pwmen_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en_req,
  output logic active,
  output logic gated_tick
);
  logic act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= 1'b0;
    else if (tick) act_q <= en_req;
  end

  assign active     = act_q;
  assign gated_tick = tick & act_q;

  // R4
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(active));

  // R4
  sync_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (active == $past(en_req)));
endmodule

// File: rtl/pwmen_pinmux.sv
module pwmen_pinmux
  import pwmen_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic [NCH-1:0] active,
  input  logic [NCH-1:0] dir,
  input  logic [NCH-1:0] dat,
  input  logic [NCH-1:0] wave,
  output logic [NCH-1:0] oe,
  output logic [NCH-1:0] out
);
  for (genvar i = 0; i < NCH; i++) begin : g_pin
    pin_owner_e owner;
    assign owner = pin_owner_e'(active[i]);
    always_comb begin
      unique case (owner)
        OWNER_PWM: begin
          oe[i]  = 1'b1;
          out[i] = wave[i];
        end
        default: begin
          oe[i]  = dir[i];
          out[i] = dat[i];
        end
      endcase
    end
  end
endmodule

// File: rtl/pwm_chan_enable.sv
module pwm_chan_enable
  import pwmen_pkg::*;
#(
  parameter int unsigned NCH   = PWMEN_NCH,
  parameter int unsigned BUS_W = PWMEN_BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [NCH-1:0]   src_tick,
  input  logic [NCH-1:0]   pwm_wave,
  input  logic [NCH-1:0]   port_dir,
  input  logic [NCH-1:0]   port_dat,
  output logic [NCH-1:0]   cnt_clk_en,
  output logic [NCH-1:0]   pin_oe,
  output logic [NCH-1:0]   pin_out
);
  logic [NCH-1:0] en_bits;
  logic [NCH-1:0] chan_act;

  pwmen_reg #(.NCH(NCH), .BUS_W(BUS_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (bus_sel),
    .wr      (bus_wr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .en_bits (en_bits)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    pwmen_sync u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (src_tick[i]),
      .en_req     (en_bits[i]),
      .active     (chan_act[i]),
      .gated_tick (cnt_clk_en[i])
    );
  end

  pwmen_pinmux #(.NCH(NCH)) u_mux (
    .active (chan_act),
    .dir    (port_dir),
    .dat    (port_dat),
    .wave   (pwm_wave),
    .oe     (pin_oe),
    .out    (pin_out)
  );

  // R6
  gate_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_clk_en & ~src_tick) == '0));

  // R7
  pin_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_clk_en & ~pin_oe) == '0));

  // R3
  rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[BUS_W-1:NCH] == '0));

  // R5
  same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (src_tick != '0)) |=>
      ((chan_act & $past(src_tick)) == ($past(bus_rdata[NCH-1:0]) & $past(src_tick))));
endmodule

// File: tb/pwm_chan_enable_bench.sv
module pwm_chan_enable_bench;
  localparam int NCH = 4;
  localparam int BW  = 8;

  typedef struct {
    logic [BW-1:0]  rdata;
    logic [NCH-1:0] clk_en;
    logic [NCH-1:0] oe;
    logic [NCH-1:0] out;
    string          tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [BW-1:0]  bus_wdata = '0;
  logic [BW-1:0]  bus_rdata;
  logic [NCH-1:0] src_tick = '0, pwm_wave = '0, port_dir = '0, port_dat = '0;
  logic [NCH-1:0] cnt_clk_en, pin_oe, pin_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb_q[$];
  event mon_ev;

  logic [NCH-1:0] m_en  = '0;
  logic [NCH-1:0] m_act = '0;

  always #4 clk = ~clk;

  pwm_chan_enable u_pwm_chan_enable (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
    .pwm_wave(pwm_wave), .port_dir(port_dir), .port_dat(port_dat),
    .cnt_clk_en(cnt_clk_en), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic step(input string tag, input logic sel, input logic wr,
                      input logic [BW-1:0] wd, input logic [NCH-1:0] tk,
                      input logic [NCH-1:0] wv, input logic [NCH-1:0] dr,
                      input logic [NCH-1:0] dt);
    exp_t e;
    logic [NCH-1:0] nx_en;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_wdata = wd; src_tick = tk;
    pwm_wave = wv; port_dir = dr; port_dat = dt;
    e.rdata  = {4'b0000, m_en};
    e.clk_en = tk & m_act;
    e.oe     = m_act | dr;
    e.out    = (m_act & wv) | (~m_act & dt);
    e.tag    = tag;
    sb_q.push_back(e);
    -> mon_ev;
    @(posedge clk);
    nx_en = (sel && wr) ? wd[NCH-1:0] : m_en;
    for (int i = 0; i < NCH; i++) if (tk[i]) m_act[i] = m_en[i];
    m_en = nx_en;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(mon_ev);
      #1;
      e = sb_q.pop_front();
      checks++;
      if ({bus_rdata, cnt_clk_en, pin_oe, pin_out} !== {e.rdata, e.clk_en, e.oe, e.out}) begin
        errors++;
        $display("FAIL %s: rdata/clk_en/oe/out actual %h/%b/%b/%b expected %h/%b/%b/%b",
                 e.tag, bus_rdata, cnt_clk_en, pin_oe, pin_out,
                 e.rdata, e.clk_en, e.oe, e.out);
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, pins follow direction and data
    step("R1", 0, 0, 8'h00, 4'b1111, 4'b1111, 4'b1010, 4'b0110);
    // R2: write with select low ignored, with write low ignored
    step("R2", 0, 1, 8'hFF, 4'b0000, 4'b0000, 4'b0011, 4'b0101);
    step("R2", 1, 0, 8'hFF, 4'b0000, 4'b0000, 4'b0011, 4'b0101);
    // R3: load 0xA5, upper bits read zero
    step("R2", 1, 1, 8'hA5, 4'b0000, 4'b1111, 4'b0000, 4'b0000);
    step("R3", 0, 0, 8'h00, 4'b0000, 4'b1111, 4'b0000, 4'b0000);
    // R4: no tick, enables held off
    step("R4", 0, 0, 8'h00, 4'b0000, 4'b1111, 4'b1000, 4'b0001);
    // R10: tick only channel 1
    step("R10", 0, 0, 8'h00, 4'b0001, 4'b0000, 4'b0000, 4'b1111);
    step("R10", 0, 0, 8'h00, 4'b0000, 4'b0001, 4'b0000, 4'b1110);
    // R6: gated ticks
    step("R6", 0, 0, 8'h00, 4'b1111, 4'b0101, 4'b0000, 4'b0000);
    step("R6", 0, 0, 8'h00, 4'b1111, 4'b1010, 4'b0000, 4'b0000);
    // R7 and R9: forced output with direction low
    step("R7", 0, 0, 8'h00, 4'b0000, 4'b0100, 4'b0000, 4'b1011);
    step("R9", 0, 0, 8'h00, 4'b0000, 4'b0001, 4'b1010, 4'b1111);
    // R5: clear and tick on same edge keeps old value
    step("R5", 1, 1, 8'h00, 4'b1111, 4'b0000, 4'b0000, 4'b0000);
    step("R5", 0, 0, 8'h00, 4'b0000, 4'b1111, 4'b0000, 4'b0000);
    // R8: next tick releases, pins return to port control
    step("R8", 0, 0, 8'h00, 4'b1111, 4'b1111, 4'b0110, 4'b1001);
    step("R8", 0, 0, 8'h00, 4'b1111, 4'b1111, 4'b0110, 4'b1001);
    // R5: set and tick on same edge
    step("R5", 1, 1, 8'h0F, 4'b1111, 4'b0000, 4'b0000, 4'b0000);
    step("R5", 0, 0, 8'h00, 4'b0010, 4'b1111, 4'b0000, 4'b0000);
    step("R10", 0, 0, 8'h00, 4'b0000, 4'b1111, 4'b0000, 4'b0000);
    // Mixed traffic
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r;
      r = $urandom;
      step((n % 2) ? "R9" : "R4", (r[0] & r[1]), r[2], r[15:8],
           r[19:16] & r[23:20], r[27:24], r[31:28], r[7:4]);
    end
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule